// File: doc/BRIEF.md
# Double-Data-Rate Burst SRAM Port

This block models a synchronous SRAM port that moves data on both clock edges, built around a small parameterized memory array. Commands are sampled on the rising edge of `clk`. A load command (`load_n` low) starts a read or a write at an external pair address. A continue command (`load_n` high) repeats the previous operation at the next address in a two-step linear burst. Each access moves two words: the even word on the rising-edge half and the odd word on the falling-edge half. The external address therefore selects a word pair and is one bit narrower than the word index.

The port has three chip enables. `sel_n` is active low. `bank_a` and `bank_b` take their active level from the strap inputs `bank_a_pol` and `bank_b_pol`, so that four devices can share the same enable wires for depth expansion. The data bus and the echo clocks each have a registered output enable. The data bus is released after any command that is not a read. The echo clocks are released only when the bank compare fails, so deselecting through `sel_n` alone leaves them running. The echo clocks are modelled only as gated copies of `clk`.

Top module: `ddr_burst_sram`

## Requirements
- R1: At a rising edge with `load_n` low and the device active, `we_n` low starts a write and `we_n` high starts a read at pair address `addr`.
- R2: The word index is {pair address, half}. Half 0 (even word) is transferred on the rising-edge half and half 1 (odd word) on the falling-edge half. The array holds 2^(AW+1) words.
- R3: A continue command (`load_n` high) after a read or write repeats that operation with word-address bits [1:0] stepping linearly modulo 4. Start 00 gives 00,01,10,11 over one load and one continue. Start 10 gives 10,11,00,01. A second continue returns to the base pair.
- R4: For a read sampled at rising edge N, `dq_out` carries the even word while `clk` is high after edge N+1, and the odd word while `clk` is low after the falling edge that follows.
- R5: For a write sampled at rising edge N, `dq_in` is captured at edge N+1 as the even word and at the following falling edge as the odd word.
- R6: The device is active only when `sel_n` is low, `bank_a` equals `bank_a_pol` and `bank_b` equals `bank_b_pol`. A load command while inactive writes nothing to the array.
- R7: `dq_oe` is 1 during the cycle after a read or read-continue is sampled. It is 0 from one cycle after a write, a chip deselect (`sel_n` high) or a bank deselect is sampled.
- R8: `echo_oe` goes to 0 one cycle after a load with a failed bank compare and stays 1 after a deselect through `sel_n` alone. While enabled, `echo_p` follows `clk` and `echo_n` follows its inverse. Both are 0 while disabled.
- R9: A continue command in a deselected state keeps that state, whatever the enables and `we_n` show.
- R10: Reset (synchronous, active high) puts the port in the bank-deselected state with `dq_oe` and `echo_oe` at 0.
- R11: A read sampled in the cycle directly after a write to the same pair returns the newly written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on rising edge, data on both edges |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Low: load a new command; high: continue |
| we_n | input | 1 | Low: write, high: read (on load) |
| addr | input | AW | Pair address (word index without bit 0) |
| sel_n | input | 1 | Active-low chip select |
| bank_a | input | 1 | Bank enable A, active level set by `bank_a_pol` |
| bank_b | input | 1 | Bank enable B, active level set by `bank_b_pol` |
| bank_a_pol | input | 1 | Strap: active level of `bank_a` |
| bank_b_pol | input | 1 | Strap: active level of `bank_b` |
| dq_in | input | DW | Write data, sampled on both edges |
| dq_out | output | DW | Read data, even word while `clk` high, odd word while low |
| dq_oe | output | 1 | Data bus drive enable |
| echo_p | output | 1 | True echo clock |
| echo_n | output | 1 | Inverted echo clock |
| echo_oe | output | 1 | Echo clock drive enable |

## Verification
The hardest case to reach from the ports is a read of a pair in the cycle right after a write to it. The write's odd word is still in a falling-edge register, and the array commit happens on the same edge as the read. The bench issues a read, then a write and then a read of the written pair on back-to-back edges, with the data words placed in the correct half-cycles. This also shows the data bus dropping for exactly the write cycle. A separate scenario walks from a running chip-deselect through a bank deselect and continues, then back to chip-deselect, and checks the echo enable at each edge.

// File: rtl/ddr_sram_pkg.sv
`timescale 1ns/1ps
package ddr_sram_pkg;
  typedef enum logic [1:0] {
    ST_BANK_OFF = 2'd0,
    ST_CHIP_OFF = 2'd1,
    ST_RD       = 2'd2,
    ST_WR       = 2'd3
  } op_state_t;
endpackage

// File: rtl/ddr_cmd_ctrl.sv
`timescale 1ns/1ps
module ddr_cmd_ctrl
  import ddr_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  input  logic          bank_a,
  input  logic          bank_b,
  input  logic          bank_a_pol,
  input  logic          bank_b_pol,
  output op_state_t     state,
  output logic [AW-1:0] pair_addr
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic bank_hit;
  assign bank_hit = (bank_a == bank_a_pol) && (bank_b == bank_b_pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BANK_OFF;
      pair_addr <= '0;
    end else if (!load_n) begin
      if (!bank_hit)  state <= ST_BANK_OFF;
      else if (sel_n) state <= ST_CHIP_OFF;
      else begin
        state     <= we_n ? ST_RD : ST_WR;
        pair_addr <= addr;
      end
    end else if (state == ST_RD || state == ST_WR) begin
      pair_addr <= pair_addr ^ STEP;
    end
  end

  AST_CONT_STEPS: assert property (@(posedge clk) disable iff (rst) (load_n && (state == ST_RD || state == ST_WR)) |=> (pair_addr == ($past(pair_addr) ^ STEP)) && (state == $past(state))); // R3
  AST_CONT_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst) (load_n && (state == ST_BANK_OFF || state == ST_CHIP_OFF)) |=> (state == $past(state))); // R9
endmodule

// File: rtl/ddr_pair_mem.sv
`timescale 1ns/1ps
module ddr_pair_mem #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_arm,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] dq_in,
  output logic [2*DW-1:0] q
);
  localparam int DEPTH = 2**AW;

  logic [2*DW-1:0] mem [DEPTH];
  logic            wr_pend;
  logic [AW-1:0]   wa;
  logic [DW-1:0]   w_even;
  logic [DW-1:0]   w_odd;

  // even half captured on the rising edge after the write command
  always_ff @(posedge clk) begin
    if (rst) wr_pend <= 1'b0;
    else     wr_pend <= wr_arm;
    if (wr_arm) begin
      wa     <= wr_addr;
      w_even <= dq_in;
    end
  end

  // odd half captured on the falling edge of the same cycle
  always_ff @(negedge clk) begin
    if (wr_pend) w_odd <= dq_in;
  end

  // pair-wide commit on the next rising edge
  always_ff @(posedge clk) begin
    if (wr_pend) mem[wa] <= {w_odd, w_even};
  end

  // registered read with bypass of the pair being committed
  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (wr_pend && wa == rd_addr) q <= {w_odd, w_even};
      else                          q <= mem[rd_addr];
    end
  end

  AST_PEND_AFTER_ARM: assert property (@(posedge clk) disable iff (rst) wr_arm |=> wr_pend); // R5
endmodule

// File: rtl/ddr_io_stage.sv
`timescale 1ns/1ps
module ddr_io_stage
  import ddr_sram_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  op_state_t       state,
  input  logic [2*DW-1:0] q,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  output logic            echo_p,
  output logic            echo_n,
  output logic            echo_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe   <= 1'b0;
      echo_oe <= 1'b0;
    end else begin
      dq_oe   <= (state == ST_RD);
      echo_oe <= (state != ST_BANK_OFF);
    end
  end

  assign dq_out = clk ? q[DW-1:0] : q[2*DW-1:DW];
  assign echo_p = echo_oe & clk;
  assign echo_n = echo_oe & ~clk;

  AST_DQ_NEEDS_ECHO: assert property (@(posedge clk) disable iff (rst) dq_oe |-> echo_oe); // R8
endmodule

// File: rtl/ddr_burst_sram.sv
`timescale 1ns/1ps
module ddr_burst_sram
  import ddr_sram_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  input  logic          bank_a,
  input  logic          bank_b,
  input  logic          bank_a_pol,
  input  logic          bank_b_pol,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          echo_p,
  output logic          echo_n,
  output logic          echo_oe
);
  op_state_t       state;
  logic [AW-1:0]   pair_addr;
  logic [2*DW-1:0] q;

  ddr_cmd_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst(rst), .load_n(load_n), .we_n(we_n), .addr(addr),
    .sel_n(sel_n), .bank_a(bank_a), .bank_b(bank_b),
    .bank_a_pol(bank_a_pol), .bank_b_pol(bank_b_pol),
    .state(state), .pair_addr(pair_addr)
  );

  ddr_pair_mem #(.DW(DW), .AW(AW)) mem_i (
    .clk(clk), .rst(rst),
    .rd_en(state == ST_RD), .rd_addr(pair_addr),
    .wr_arm(state == ST_WR), .wr_addr(pair_addr),
    .dq_in(dq_in), .q(q)
  );

  ddr_io_stage #(.DW(DW)) io_i (
    .clk(clk), .rst(rst), .state(state), .q(q),
    .dq_out(dq_out), .dq_oe(dq_oe),
    .echo_p(echo_p), .echo_n(echo_n), .echo_oe(echo_oe)
  );

  logic bank_ok;
  assign bank_ok = (bank_a == bank_a_pol) && (bank_b == bank_b_pol);

  AST_BANK_OFF_ECHO: assert property (@(posedge clk) disable iff (rst) (!load_n && !bank_ok) |=> ##1 !echo_oe); // R8
  AST_CHIP_OFF_ECHO_ON: assert property (@(posedge clk) disable iff (rst) (!load_n && bank_ok && sel_n) |=> ##1 (echo_oe && !dq_oe)); // R7
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst) (!load_n && bank_ok && !sel_n && we_n) |=> ##1 dq_oe); // R1
  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (rst) (!load_n && bank_ok && !sel_n && !we_n) |=> ##1 !dq_oe); // R7
  AST_RESET_RELEASED: assert property (@(posedge clk) rst |=> (!dq_oe && !echo_oe)); // R10
endmodule

// File: tb/ddr_burst_sram_tb_top.sv
`timescale 1ns/1ps
module ddr_burst_sram_tb_top;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NW = 2**(AW+1);
  localparam int K_RD = 0, K_WR = 1, K_CONT = 2, K_CHIP = 3, K_BANK = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          load_n = 1'b0, we_n = 1'b1, sel_n = 1'b1;
  logic          bank_a = 1'b0, bank_b = 1'b0, bank_a_pol = 1'b0, bank_b_pol = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe, echo_p, echo_n, echo_oe;

  ddr_burst_sram #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .load_n(load_n), .we_n(we_n), .addr(addr),
    .sel_n(sel_n), .bank_a(bank_a), .bank_b(bank_b),
    .bank_a_pol(bank_a_pol), .bank_b_pol(bank_b_pol), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .echo_p(echo_p), .echo_n(echo_n), .echo_oe(echo_oe)
  );

  logic [DW-1:0] ref_mem [NW];
  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic after_rise(); @(posedge clk); #1; endtask
  task automatic after_fall(); @(negedge clk); #1; endtask

  task automatic cmd(input int k, input logic [AW-1:0] a);
    load_n = (k == K_CONT) ? 1'b1 : 1'b0;
    we_n   = (k == K_WR) ? 1'b0 : 1'b1;
    addr   = a;
    sel_n  = (k == K_CHIP) ? 1'b1 : 1'b0;
    bank_a = (k == K_BANK) ? ~bank_a_pol : bank_a_pol;
    bank_b = bank_b_pol;
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] p, input int h, input int s);
    return DW'(int'(p) * 37 + h * 11 + s * 101 + 23040);
  endfunction

  function automatic logic [AW-1:0] beat_pair(input logic [AW-1:0] base, input int j);
    return base ^ AW'(j & 1);
  endfunction

  // R1 R5 R2: load write then ncont continues, data on both edges
  task automatic burst_write(input logic [AW-1:0] base, input int ncont, input int seed);
    for (int t = 0; t <= ncont + 2; t++) begin
      after_rise();
      if (t >= 2) dq_in = pat(beat_pair(base, t-2), 1, seed);
      if (t == 0)          cmd(K_WR, base);
      else if (t <= ncont) cmd(K_CONT, base);
      else                 cmd(K_CHIP, base);
      after_fall();
      if (t >= 1 && t - 1 <= ncont) dq_in = pat(beat_pair(base, t-1), 0, seed);
    end
    for (int j = 0; j <= ncont; j++) begin
      ref_mem[{beat_pair(base, j), 1'b0}] = pat(beat_pair(base, j), 0, seed);
      ref_mem[{beat_pair(base, j), 1'b1}] = pat(beat_pair(base, j), 1, seed);
    end
  endtask

  // R4 R3 R7: read burst, compare both halves, bus release after deselect
  task automatic burst_read(input logic [AW-1:0] base, input int ncont);
    logic [AW-1:0] bp;
    for (int t = 0; t <= ncont + 2; t++) begin
      after_rise();
      if (t >= 2) begin
        bp = beat_pair(base, t-2);
        chk(dq_oe === 1'b1, "R7 dq_oe during read beat", 32'(dq_oe), 32'd1);
        chk(dq_out === ref_mem[{bp, 1'b0}], "R4 R3 even word of read beat", 32'(dq_out), 32'(ref_mem[{bp, 1'b0}]));
      end
      if (t == 0)          cmd(K_RD, base);
      else if (t <= ncont) cmd(K_CONT, base);
      else                 cmd(K_CHIP, base);
      after_fall();
      if (t >= 2) begin
        bp = beat_pair(base, t-2);
        chk(dq_out === ref_mem[{bp, 1'b1}], "R2 R3 odd word of read beat", 32'(dq_out), 32'(ref_mem[{bp, 1'b1}]));
      end
    end
    after_rise();
    chk(dq_oe === 1'b0, "R7 dq_oe released after chip deselect", 32'(dq_oe), 32'd0);
  endtask

  task automatic test_reset();
    cmd(K_CHIP, '0);
    rst = 1'b1;
    repeat (3) after_rise();
    chk(dq_oe === 1'b0 && echo_oe === 1'b0, "R10 outputs released in reset", {dq_oe, echo_oe}, 32'd0);
    rst = 1'b0;
    after_rise();
    chk(echo_oe === 1'b0, "R10 echo still off first cycle after reset", 32'(echo_oe), 32'd0);
    chk(echo_p === 1'b0, "R8 echo_p low while disabled", 32'(echo_p), 32'd0);
    after_rise();
    chk(echo_oe === 1'b1, "R8 echo on after chip deselect", 32'(echo_oe), 32'd1);
  endtask

  // R8 R9: bank deselect stops echo; continues keep it off; sel_n-only keeps it on
  task automatic test_echo();
    after_rise(); cmd(K_BANK, '0);
    after_rise();
    chk(echo_oe === 1'b1, "R8 echo unchanged in sampling cycle", 32'(echo_oe), 32'd1);
    cmd(K_CONT, '0);
    after_rise();
    chk(echo_oe === 1'b0, "R8 echo off one cycle after bank deselect", 32'(echo_oe), 32'd0);
    cmd(K_CONT, '0);
    after_rise();
    chk(echo_oe === 1'b0 && dq_oe === 1'b0, "R9 continue keeps bank deselect", {echo_oe, dq_oe}, 32'd0);
    cmd(K_CHIP, '0);
    after_rise();
    chk(echo_oe === 1'b0, "R8 echo off until chip deselect registers", 32'(echo_oe), 32'd0);
    after_rise();
    chk(echo_oe === 1'b1 && echo_p === 1'b1 && echo_n === 1'b0, "R8 echo high phase", {echo_oe, echo_p, echo_n}, 32'b110);
    after_fall();
    chk(echo_p === 1'b0 && echo_n === 1'b1 && dq_oe === 1'b0, "R8 echo low phase", {echo_p, echo_n, dq_oe}, 32'b010);
  endtask

  // R6: writes while inactive must not reach the array
  task automatic test_inactive_write(input logic [AW-1:0] p);
    after_rise(); cmd(K_BANK, p); we_n = 1'b0;
    dq_in = 16'hDEAD;
    after_rise(); cmd(K_CONT, p); we_n = 1'b0;
    after_rise(); cmd(K_CHIP, p); we_n = 1'b0;
    dq_in = 16'hBEEF;
    after_rise(); cmd(K_CONT, p); we_n = 1'b0;
    after_rise(); cmd(K_CHIP, p);
    after_rise();
    burst_read(p, 1);
  endtask

  // R11 R7: read, write, read of written pair on consecutive edges
  task automatic test_coherence(input logic [AW-1:0] p0, input logic [AW-1:0] p1);
    logic [DW-1:0] ev, od;
    ev = 16'h1357; od = 16'h2468;
    after_rise(); cmd(K_RD, p0);
    after_rise(); cmd(K_WR, p1);
    after_rise();
    chk(dq_oe === 1'b1 && dq_out === ref_mem[{p0, 1'b0}], "R4 read before write even", 32'(dq_out), 32'(ref_mem[{p0, 1'b0}]));
    cmd(K_RD, p1);
    after_fall();
    chk(dq_out === ref_mem[{p0, 1'b1}], "R4 read before write odd", 32'(dq_out), 32'(ref_mem[{p0, 1'b1}]));
    dq_in = ev;
    after_rise();
    chk(dq_oe === 1'b0, "R7 bus released one cycle after write", 32'(dq_oe), 32'd0);
    dq_in = od;
    cmd(K_CHIP, '0);
    after_rise();
    chk(dq_oe === 1'b1 && dq_out === ev, "R11 back-to-back read even", 32'(dq_out), 32'(ev));
    after_fall();
    chk(dq_out === od, "R11 back-to-back read odd", 32'(dq_out), 32'(od));
    ref_mem[{p1, 1'b0}] = ev;
    ref_mem[{p1, 1'b1}] = od;
    after_rise();
  endtask

  // R6: each strap setting, enables matched to it
  task automatic test_straps();
    for (int s = 0; s < 4; s++) begin
      after_rise();
      bank_a_pol = s[0];
      bank_b_pol = s[1];
      cmd(K_CHIP, '0);
      burst_write(AW'(48 + s), 0, 7 + s);
      burst_read(AW'(48 + s), 0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    burst_write(AW'(4), 1, 1);        // R3 start 00: words 08..0B
    burst_read(AW'(4), 1);            // R3 00,01,10,11
    burst_read(AW'(5), 2);            // R3 start 10: 10,11,00,01 then wrap to 10
    burst_write(AW'(16), 2, 2);       // R3 second continue rewrites base pair
    burst_read(AW'(16), 1);
    test_echo();
    test_inactive_write(AW'(4));      // R6
    test_coherence(AW'(4), AW'(32));  // R11
    test_straps();                    // R6
    summary();
    $finish;
  end
endmodule